// File: doc/BRIEF.md
# Packed Signed Compare Unit

This block compares two packed operand vectors of up to 512 bits, element by element, using a signed strict greater-than test. The element width can be 8, 16 or 32 bits. The active vector length can be 64, 128, 256 or 512 bits. A single compare datapath drives two result forms.

In the vector forms, every element of a destination vector is filled with all ones or all zeros. The bits above the active length are either copied from a supplied prior destination value or cleared. In the predicate form, the unit produces one bit per element. Those bits are gated by an optional zeroing writemask. For 32-bit elements, the second operand can instead be a single scalar that is broadcast to every lane.

The result is captured in an output register one cycle after a valid strobe. A pulse on `out_valid` accompanies that update. Illegal combinations raise an error flag and force the results to zero.

Top module: `packed_cmp_unit`

## Requirements
- R1: Each element compares the first operand against the second as a two's-complement signed value. The result is true only when the first operand is strictly greater, so equal elements give false.
- R2: `esz` selects the element width: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits. Element e occupies bits [e*w +: w]. In the vector forms, a true element is written as all ones across its width and a false element as zero.
- R3: `vlen` selects the active length: 0 for 64 bits, 1 for 128, 2 for 256, 3 for 512. In the clearing vector form (`rmode` = 1), every result bit at or above the active length is 0.
- R4: In the preserving vector form (`rmode` = 0), every result bit at or above the active length equals the same bit of `prior`.
- R5: In the predicate form (`rmode` = 2), the element count is the active length divided by the element width. Bit j of `res_mask` belongs to element j. Mask bits at or above the count are 0, and `res_vec` is all zero.
- R6: In the predicate form with `wm_en` = 1, an element whose `wmask` bit is 0 yields 0, with no merge. With `wm_en` = 0, every element within the count is active.
- R7: With `bcast` = 1, 32-bit elements and the predicate form, every lane of `opa` is compared against `opb[31:0]`. For any other element width or form, `bcast` has no effect.
- R8: The output registers load in the cycle after `in_valid` is sampled high, and `out_valid` is high for exactly that one cycle. Without `in_valid`, the outputs hold their values.
- R9: The following combinations are rejected, raising `res_err` and forcing both results to zero: `esz` = 3, `rmode` = 3, or the preserving form with `vlen` = 3.
- R10: During and right after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| opa | input | 512 | First operand vector |
| opb | input | 512 | Second operand vector |
| prior | input | 512 | Prior destination value for the preserving form |
| esz | input | 2 | Element width code |
| vlen | input | 2 | Active length code |
| rmode | input | 2 | Result form: 0 preserve, 1 clear, 2 predicate |
| wm_en | input | 1 | Writemask enable |
| wmask | input | 64 | Writemask, one bit per element |
| bcast | input | 1 | Scalar broadcast of opb[31:0] |
| out_valid | output | 1 | Result update strobe |
| res_vec | output | 512 | Vector-form result |
| res_mask | output | 64 | Predicate-form result |
| res_err | output | 1 | Rejected-combination flag |

## Verification
The bench uses several stimulus classes, each aimed at a different fault:

- **Sign-boundary pairs.** Operand pairs of 0x80..0x7F at each element width, in both orders, separate a signed compare from an unsigned one.
- **Equal operands.** These separate a strict compare from greater-or-equal.
- **Random operands.** These cover every width, length and form combination, with lanes that are sometimes equal and with random writemasks. They separate correct lane slicing, length handling and upper-bit handling from off-by-one or wrong-width faults.
- **Broadcast patterns.** A scalar operand is paired with varied upper lanes, and the same pattern is repeated at byte width. This shows whether broadcast substitutes the scalar only where it should.
- **Rejected and idle cycles.** These confirm the error path and that the outputs hold between strobes.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
    typedef enum logic [1:0] {
        ESZ_B   = 2'd0,
        ESZ_W   = 2'd1,
        ESZ_D   = 2'd2,
        ESZ_BAD = 2'd3
    } esz_e;

    typedef enum logic [1:0] {
        VL_64  = 2'd0,
        VL_128 = 2'd1,
        VL_256 = 2'd2,
        VL_512 = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        RM_KEEP = 2'd0,
        RM_ZERO = 2'd1,
        RM_MASK = 2'd2,
        RM_BAD  = 2'd3
    } rmode_e;
endpackage

// File: rtl/pcmp_lanes.sv
module pcmp_lanes #(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0]      opa,
    input  logic [VEC_W-1:0]      opb,
    input  logic                  bcast_eff,
    output logic [VEC_W/8-1:0]    gt8,
    output logic [VEC_W/16-1:0]   gt16,
    output logic [VEC_W/32-1:0]   gt32
);
    localparam int N8  = VEC_W / 8;
    localparam int N16 = VEC_W / 16;
    localparam int N32 = VEC_W / 32;

    for (genvar i = 0; i < N8; i++) begin : g_b
        assign gt8[i] = $signed(opa[i*8 +: 8]) > $signed(opb[i*8 +: 8]);
    end

    for (genvar i = 0; i < N16; i++) begin : g_w
        assign gt16[i] = $signed(opa[i*16 +: 16]) > $signed(opb[i*16 +: 16]);
    end

    for (genvar i = 0; i < N32; i++) begin : g_d
        logic [31:0] rhs;
        assign rhs     = bcast_eff ? opb[31:0] : opb[i*32 +: 32];
        assign gt32[i] = $signed(opa[i*32 +: 32]) > $signed(rhs);
    end

    always_comb begin
        if (opa == opb) begin
            // R1
            eq_false_chk: assert ((gt8 == '0) && (gt16 == '0))
                else $error("equal operands produced a true lane");
        end
    end
endmodule

// File: rtl/pcmp_shape.sv
module pcmp_shape
    import pcmp_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W/8-1:0]   gt8,
    input  logic [VEC_W/16-1:0]  gt16,
    input  logic [VEC_W/32-1:0]  gt32,
    input  logic [VEC_W-1:0]     prior,
    input  esz_e                 esz,
    input  vlen_e                vlen,
    input  rmode_e               rmode,
    input  logic                 wm_en,
    input  logic [VEC_W/8-1:0]   wmask,
    output logic [VEC_W-1:0]     vec,
    output logic [VEC_W/8-1:0]   mask,
    output logic                 bad
);
    localparam int NB     = VEC_W / 8;
    localparam int MASK_W = VEC_W / 8;

    logic [MASK_W-1:0] e16;
    logic [MASK_W-1:0] e32;
    int                act_bytes;
    int                count;

    assign e16 = MASK_W'(gt16);
    assign e32 = MASK_W'(gt32);

    always_comb begin
        logic flag;
        act_bytes = 8 << int'(vlen);
        count     = act_bytes >> int'(esz);
        bad       = (esz == ESZ_BAD) || (rmode == RM_BAD) ||
                    ((rmode == RM_KEEP) && (vlen == VL_512));
        vec  = '0;
        mask = '0;
        for (int k = 0; k < NB; k++) begin
            case (esz)
                ESZ_B:   flag = gt8[k];
                ESZ_W:   flag = gt16[k/2];
                default: flag = gt32[k/4];
            endcase
            if (k < act_bytes)
                vec[k*8 +: 8] = {8{flag}};
            else if (rmode == RM_KEEP)
                vec[k*8 +: 8] = prior[k*8 +: 8];
            else
                vec[k*8 +: 8] = 8'h00;
        end
        for (int j = 0; j < MASK_W; j++) begin
            case (esz)
                ESZ_B:   flag = gt8[j];
                ESZ_W:   flag = e16[j];
                default: flag = e32[j];
            endcase
            mask[j] = (j < count) && (!wm_en || wmask[j]) && flag;
        end
        if (rmode == RM_MASK) vec  = '0;
        else                  mask = '0;
        if (bad) begin
            vec  = '0;
            mask = '0;
        end
    end
endmodule

// File: rtl/packed_cmp_unit.sv
module packed_cmp_unit
    import pcmp_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [VEC_W-1:0]     opa,
    input  logic [VEC_W-1:0]     opb,
    input  logic [VEC_W-1:0]     prior,
    input  logic [1:0]           esz,
    input  logic [1:0]           vlen,
    input  logic [1:0]           rmode,
    input  logic                 wm_en,
    input  logic [VEC_W/8-1:0]   wmask,
    input  logic                 bcast,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     res_vec,
    output logic [VEC_W/8-1:0]   res_mask,
    output logic                 res_err
);
    localparam int MASK_W = VEC_W / 8;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [VEC_W-1:0]  vec;
        logic [MASK_W-1:0] msk;
    } state_t;

    state_t st_d, st_q;

    logic                bcast_eff;
    logic [VEC_W/8-1:0]  gt8;
    logic [VEC_W/16-1:0] gt16;
    logic [VEC_W/32-1:0] gt32;
    logic [VEC_W-1:0]    shp_vec;
    logic [MASK_W-1:0]   shp_mask;
    logic                shp_bad;

    assign bcast_eff = bcast && (esz_e'(esz) == ESZ_D) && (rmode_e'(rmode) == RM_MASK);

    pcmp_lanes #(.VEC_W(VEC_W)) i_lanes (
        .opa(opa), .opb(opb), .bcast_eff(bcast_eff),
        .gt8(gt8), .gt16(gt16), .gt32(gt32)
    );

    pcmp_shape #(.VEC_W(VEC_W)) i_shape (
        .gt8(gt8), .gt16(gt16), .gt32(gt32), .prior(prior),
        .esz(esz_e'(esz)), .vlen(vlen_e'(vlen)), .rmode(rmode_e'(rmode)),
        .wm_en(wm_en), .wmask(wmask),
        .vec(shp_vec), .mask(shp_mask), .bad(shp_bad)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.err = shp_bad;
            st_d.vec = shp_vec;
            st_d.msk = shp_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign res_err   = st_q.err;
    assign res_vec   = st_q.vec;
    assign res_mask  = st_q.msk;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(res_vec) && $stable(res_mask));
    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> (res_vec == '0) && (res_mask == '0));
    // R5
    mask_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rmode == 2'd2 && esz != 2'd3) |=> (res_vec == '0));
    // R5
    mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rmode == 2'd2 && esz == 2'd2 && vlen == 2'd1)
        |=> (res_mask[MASK_W-1:4] == '0));
    // R3
    zero_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rmode == 2'd1 && vlen == 2'd1)
        |=> (res_vec[VEC_W-1:128] == '0));
    // R4
    keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rmode == 2'd0 && vlen == 2'd1 && esz != 2'd3)
        |=> (res_vec[VEC_W-1:128] == $past(prior[VEC_W-1:128])));
endmodule

// File: tb/test_packed_cmp_unit.sv
module test_packed_cmp_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] opa = '0, opb = '0, prior = '0;
    logic [1:0]   esz = '0, vlen = '0, rmode = '0;
    logic         wm_en = 1'b0, bcast = 1'b0;
    logic [63:0]  wmask = '0;
    logic         out_valid, res_err;
    logic [511:0] res_vec;
    logic [63:0]  res_mask;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    packed_cmp_unit i_packed_cmp_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .prior(prior), .esz(esz), .vlen(vlen), .rmode(rmode), .wm_en(wm_en),
        .wmask(wmask), .bcast(bcast), .out_valid(out_valid), .res_vec(res_vec),
        .res_mask(res_mask), .res_err(res_err)
    );

    typedef struct packed {
        logic [31:0] pa;
        logic [31:0] pb;
        logic [1:0]  sz;
        logic [1:0]  vl;
        logic [1:0]  md;
        logic        wen;
        logic        bc;
    } vec_t;

    localparam vec_t TABLE [8] = '{
        '{32'h7F80_0102, 32'h8080_0201, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0},
        '{32'h8000_7FFF, 32'h7FFF_8000, 2'd1, 2'd2, 2'd1, 1'b0, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_0000, 2'd2, 2'd1, 2'd0, 1'b0, 1'b0},
        '{32'h0000_0001, 32'hFFFF_FFFF, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0},
        '{32'h1234_5678, 32'h1234_5600, 2'd0, 2'd3, 2'd2, 1'b1, 1'b0},
        '{32'h8001_0000, 32'h8000_0001, 2'd1, 2'd1, 2'd2, 1'b0, 1'b0},
        '{32'h0000_0010, 32'h0000_0008, 2'd2, 2'd3, 2'd2, 1'b1, 1'b1},
        '{32'hC0C0_C0C0, 32'hBFBF_BFBF, 2'd0, 2'd2, 2'd1, 1'b0, 1'b1}
    };

    function automatic bit sgt(input logic [511:0] a, input logic [511:0] b,
                               input int e, input int ew);
        longint x = 0;
        longint y = 0;
        for (int t = 0; t < ew; t++) begin
            x[t] = a[e*ew + t];
            y[t] = b[e*ew + t];
        end
        if (x[ew-1]) x = x - (longint'(1) << ew);
        if (y[ew-1]) y = y - (longint'(1) << ew);
        return x > y;
    endfunction

    function automatic bit is_bad(input int sz, input int vl, input int md);
        return (sz == 3) || (md == 3) || (md == 0 && vl == 3);
    endfunction

    function automatic logic [511:0] mdl_vec(input logic [511:0] a, b, p,
                                             input int sz, vl, md);
        logic [511:0] r = '0;
        int ew = 8 << sz;
        int lb = 64 << vl;
        if (is_bad(sz, vl, md) || md == 2) return '0;
        for (int pos = 0; pos < 512; pos++)
            r[pos] = (pos < lb) ? sgt(a, b, pos / ew, ew) : ((md == 0) ? p[pos] : 1'b0);
        return r;
    endfunction

    function automatic logic [63:0] mdl_mask(input logic [511:0] a, b,
                                             input int sz, vl, md,
                                             input logic wen, input logic [63:0] wm,
                                             input logic bc);
        logic [63:0]  m = '0;
        logic [511:0] b2 = b;
        int ew = 8 << sz;
        int cnt = (64 << vl) / ew;
        if (is_bad(sz, vl, md) || md != 2) return '0;
        if (bc && sz == 2) b2 = {16{b[31:0]}};
        for (int j = 0; j < cnt; j++)
            m[j] = (!wen || wm[j]) && sgt(a, b2, j, ew);
        return m;
    endfunction

    task automatic drive(input logic [511:0] a, b, p, input int sz, vl, md,
                         input logic wen, input logic [63:0] wm, input logic bc);
        @(negedge clk);
        opa = a; opb = b; prior = p;
        esz = 2'(sz); vlen = 2'(vl); rmode = 2'(md);
        wm_en = wen; wmask = wm; bcast = bc;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input string req, input logic [511:0] ev,
                         input logic [63:0] em, input logic ee, input logic evld);
        n_chk++;
        if (res_vec !== ev || res_mask !== em || res_err !== ee || out_valid !== evld) begin
            n_bad++;
            $display("FAIL %s: got vec=%h mask=%h err=%b vld=%b exp vec=%h mask=%h err=%b vld=%b",
                     req, res_vec, res_mask, res_err, out_valid, ev, em, ee, evld);
        end
    endtask

    task automatic run(input string req, input logic [511:0] a, b, p,
                       input int sz, vl, md, input logic wen,
                       input logic [63:0] wm, input logic bc);
        drive(a, b, p, sz, vl, md, wen, wm, bc);
        check(req, mdl_vec(a, b, p, sz, vl, md),
              mdl_mask(a, b, sz, vl, md, wen, wm, bc), is_bad(sz, vl, md), 1'b1);
    endtask

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [511:0] a, b, p, sv_vec;
        logic [63:0]  sv_mask;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", '0, '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", '0, '0, 1'b0, 1'b0);

        // R2 R3 R5 R6 R7: table walk
        foreach (TABLE[i]) begin
            run("R2_R5_tbl", {16{TABLE[i].pa}}, {16{TABLE[i].pb}}, {16{32'hDEAD_BEEF}},
                int'(TABLE[i].sz), int'(TABLE[i].vl), int'(TABLE[i].md),
                TABLE[i].wen, 64'hA5C3_0FF0_96E1_5A3C, TABLE[i].bc);
        end

        // R1: sign boundary per width, both orders
        run("R1_b", {64{8'h7F}}, {64{8'h80}}, '0, 0, 3, 1, 1'b0, '0, 1'b0);
        check("R1_b_ones", {512{1'b1}}, '0, 1'b0, 1'b1);
        run("R1_b", {64{8'h80}}, {64{8'h7F}}, '0, 0, 3, 1, 1'b0, '0, 1'b0);
        check("R1_b_zero", '0, '0, 1'b0, 1'b1);
        run("R1_w", {32{16'h7FFF}}, {32{16'h8000}}, '0, 1, 3, 1, 1'b0, '0, 1'b0);
        check("R1_w_ones", {512{1'b1}}, '0, 1'b0, 1'b1);
        run("R1_d", {16{32'h8000_0000}}, {16{32'h7FFF_FFFF}}, '0, 2, 3, 2, 1'b0, '0, 1'b0);
        check("R1_d_zero", '0, '0, 1'b0, 1'b1);
        // R1: equal operands give false
        a = rnd512();
        for (int s = 0; s < 3; s++) begin
            run("R1_eq", a, a, '0, s, 3, 1, 1'b0, '0, 1'b0);
            check("R1_eq_vec", '0, '0, 1'b0, 1'b1);
            run("R1_eq", a, a, '0, s, 3, 2, 1'b0, '0, 1'b0);
            check("R1_eq_mask", '0, '0, 1'b0, 1'b1);
        end

        // R4: preserved upper bits at 128
        p = rnd512();
        run("R4", {64{8'h05}}, {64{8'h01}}, p, 0, 1, 0, 1'b0, '0, 1'b0);
        check("R4_explicit", {p[511:128], {128{1'b1}}}, '0, 1'b0, 1'b1);

        // R6: writemask disabled vs enabled
        run("R6_nowm", {64{8'h10}}, '0, '0, 0, 3, 2, 1'b0, 64'h0, 1'b0);
        check("R6_all", '0, {64{1'b1}}, 1'b0, 1'b1);
        run("R6_wm", {64{8'h10}}, '0, '0, 0, 3, 2, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0);
        check("R6_zeroing", '0, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b1);

        // R7: broadcast on dwords, ignored on bytes and vector form
        b = rnd512();
        b[31:0] = 32'h0000_0000;
        run("R7_bc", {8{32'h0000_0001, 32'hFFFF_FFFF}}, b, '0, 2, 3, 2, 1'b0, '0, 1'b1);
        check("R7_bc_explicit", '0, 64'h0000_0000_0000_AAAA, 1'b0, 1'b1);
        a = rnd512();
        run("R7_ign_b", a, b, '0, 0, 3, 2, 1'b0, '0, 1'b1);
        run("R7_ign_vec", a, b, '0, 2, 3, 1, 1'b0, '0, 1'b1);

        // R9: rejected combinations
        run("R9_keep512", a, b, p, 0, 3, 0, 1'b0, '0, 1'b0);
        run("R9_esz3", a, b, p, 3, 1, 1, 1'b0, '0, 1'b0);
        run("R9_mode3", a, b, p, 1, 1, 3, 1'b0, '0, 1'b0);
        check("R9_explicit", '0, '0, 1'b1, 1'b1);

        // R8: hold without strobe
        run("R8", {64{8'h22}}, {64{8'h11}}, '0, 0, 2, 1, 1'b0, '0, 1'b0);
        sv_vec = res_vec;
        sv_mask = res_mask;
        @(negedge clk);
        opa = '0; opb = {512{1'b1}}; rmode = 2'd2;
        repeat (3) @(negedge clk);
        check("R8_hold", sv_vec, sv_mask, 1'b0, 1'b0);

        // R2 R3 R4 R5 R6: random sweep over every combination
        for (int s = 0; s < 3; s++)
            for (int l = 0; l < 4; l++)
                for (int m = 0; m < 3; m++)
                    for (int it = 0; it < 4; it++) begin
                        a = rnd512();
                        b = rnd512();
                        for (int w = 0; w < 16; w++)
                            if ($urandom % 3 == 0) b[w*32 +: 32] = a[w*32 +: 32];
                        run("R2_R3_R4_R5_R6_rnd", a, b, rnd512(), s, l, m,
                            1'($urandom), {$urandom, $urandom}, 1'($urandom));
                    end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule